// File: doc/BRIEF.md
# Framed Three-Sample Moving Average

This block smooths a stream of 14-bit two's-complement samples. Each input sample comes with a 2-bit position code that says whether the cycle is empty, opens a frame, continues a frame, or closes a frame. For every sample that carries data, the block returns the mean of that sample and the two samples before it in the same frame. At the start of a frame, the missing earlier samples count as zero, so history never leaks from one frame into the next.

Dividing by three uses a fixed-point shortcut. The three-term sum is multiplied by 85 and then shifted right by 8 bits, with the shift keeping the sign. The position code travels beside the data with the same two-cycle latency, so every result keeps its place in the frame. Between valid results the data output keeps its last value.

Top module: `framed_mean3`

## Requirements
- R1: While rst_ni is low, data_o reads 0 and tag_o reads 00, whatever is driven on data_i and tag_i.
- R2: tag_o equals the tag_i value presented two rising edges earlier, and a result for a sample on data_i appears on data_o after the same two edges.
- R3: The position code is fixed as follows: 00 means no data, 01 means the first sample of a frame, 10 means a middle sample and 11 means the last sample. Every code other than 00 produces a result.
- R4: For a sample tagged 01 with value x, the result is floor(x*85/256), because the two earlier samples count as zero.
- R5: For the second sample of a frame, the result is floor((x0+x1)*85/256), where x0 is the first sample.
- R6: From the third sample of a frame onward, the result is floor((a+b+c)*85/256) over the three most recent samples of that frame.
- R7: A sample tagged 01 discards every sample of earlier frames, even when an earlier frame never reached a tag of 11.
- R8: Negative sums are shifted arithmetically, which rounds toward minus infinity. For example, a lone sample of -1 gives -1.
- R9: Full-scale inputs do not overflow. Three samples of 8191 give 8159, and three samples of -8192 give -8160.
- R10: While tag_o is 00, data_o keeps the last result it showed. After reset, that value is 0.
- R11: A cycle tagged 00 inside a frame leaves the stored history unchanged, so the next sample averages with the samples from before the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| data_i | input | 14 | Input sample, two's complement |
| tag_i | input | 2 | Frame position of data_i (00 none, 01 first, 10 middle, 11 last) |
| data_o | output | 14 | Three-sample mean, two's complement |
| tag_o | output | 2 | tag_i delayed to line up with data_o |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of bug:
- **Frame start:** a design that failed to clear history at a new frame would mix values from the previous frame into the first two results.
- **Idle gaps:** a design that shifted its history on empty cycles would push zeros into the window in the middle of a frame.
- **Small negative sums:** a design that used a logical shift would turn these into large positive values.
- **Full-scale inputs:** a design with a narrow sum would wrap around at full scale.
- **Hold and alignment:** a design that let data_o change on empty cycles, or delayed the tag by a different amount, would show values that do not match tag_o.

Random frames of random length, with idle cycles mixed in, cover the steady-state average.

// File: rtl/framed_mean3_pkg.sv
package framed_mean3_pkg;

  typedef enum logic [1:0] {
    TAG_IDLE  = 2'b00,
    TAG_FIRST = 2'b01,
    TAG_MID   = 2'b10,
    TAG_LAST  = 2'b11
  } frame_tag_e;

endpackage

// File: rtl/mean3_taps.sv
module mean3_taps
  import framed_mean3_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int TAPS   = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   tag_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [TAPS-1:0][DATA_W-1:0]  taps_o,
  output logic [1:0]                   tag_o
);

  logic [TAPS-1:0][DATA_W-1:0] tap_q, tap_d;
  logic [1:0]                  tag_q;
  logic                        load_en;

  assign load_en = (frame_tag_e'(tag_i) != TAG_IDLE);

  // next-state: newest sample always enters tap 0
  always_comb begin
    tap_d    = tap_q;
    tap_d[0] = data_i;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_tap_next
    logic [DATA_W-1:0] older_d;
    always_comb begin
      if (frame_tag_e'(tag_i) == TAG_FIRST) older_d = '0;
      else                                  older_d = tap_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tap_q[k] <= '0;
      else if (load_en) tap_q[k] <= older_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tap_q[0] <= '0;
    else if (load_en) tap_q[0] <= tap_d[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= '0;
    else         tag_q <= tag_i;
  end

  assign taps_o = tap_q;
  assign tag_o  = tag_q;

  // R4
  first_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i == 2'b01) |=> (tap_q[1] == '0 && tap_q[2] == '0));

  // R11
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i == 2'b00) |=> ($stable(tap_q[0]) && $stable(tap_q[1]) && $stable(tap_q[2])));

  // R6
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i[1] == 1'b1) |=> (tap_q[1] == $past(tap_q[0]) && tap_q[2] == $past(tap_q[1])));

endmodule

// File: rtl/mean3_scale.sv
module mean3_scale #(
  parameter int DATA_W = 14,
  parameter int TAPS   = 3,
  parameter int COEF   = 85,
  parameter int COEF_W = 7,
  parameter int SHIFT  = 8
) (
  input  logic [TAPS-1:0][DATA_W-1:0] taps_i,
  output logic [DATA_W-1:0]           mean_o
);

  localparam int SUM_W  = DATA_W + $clog2(TAPS);
  localparam int PROD_W = SUM_W + COEF_W + 1;

  logic signed [SUM_W-1:0]  sum;
  logic signed [COEF_W:0]   coef_s;
  logic signed [PROD_W-1:0] product;

  assign coef_s = (COEF_W+1)'(COEF);

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum = sum + {{(SUM_W-DATA_W){taps_i[k][DATA_W-1]}}, taps_i[k]};
    end
  end

  assign product = sum * coef_s;
  assign mean_o  = DATA_W'(product >>> SHIFT);

endmodule

// File: rtl/framed_mean3.sv
module framed_mean3
  import framed_mean3_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int TAPS   = 3,
  parameter int COEF   = 85,
  parameter int COEF_W = 7,
  parameter int SHIFT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        tag_i,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        tag_o
);

  logic [TAPS-1:0][DATA_W-1:0] taps;
  logic [1:0]                  stage_tag;
  logic [DATA_W-1:0]           mean;
  logic [DATA_W-1:0]           data_q, data_d;
  logic [1:0]                  tag_q;
  logic                        out_en;

  mean3_taps #(.DATA_W(DATA_W), .TAPS(TAPS)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (tag_i),
    .data_i (data_i),
    .taps_o (taps),
    .tag_o  (stage_tag)
  );

  mean3_scale #(
    .DATA_W(DATA_W), .TAPS(TAPS), .COEF(COEF), .COEF_W(COEF_W), .SHIFT(SHIFT)
  ) u_scale (
    .taps_i (taps),
    .mean_o (mean)
  );

  assign out_en = (frame_tag_e'(stage_tag) != TAG_IDLE);

  always_comb begin
    data_d = data_q;
    if (out_en) data_d = mean;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      tag_q  <= '0;
    end else begin
      data_q <= data_d;
      tag_q  <= stage_tag;
    end
  end

  assign data_o = data_q;
  assign tag_o  = tag_q;

  // R2
  tag_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tag_o == $past(stage_tag)));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_tag == 2'b00) |=> $stable(data_o));

endmodule

// File: tb/framed_mean3_tb_top.sv
module framed_mean3_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 14;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [DATA_W-1:0] data_i;
  logic [1:0]        tag_i;
  logic [DATA_W-1:0] data_o;
  logic [1:0]        tag_o;

  typedef struct {
    int         due;
    logic [1:0] tag;
    int         value;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  int   ha = 0, hb = 0, hc = 0, last_out = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  framed_mean3 dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .tag_i  (tag_i),
    .data_o (data_o),
    .tag_o  (tag_o)
  );

  function automatic int mean_of(int s);
    int p;
    p = s * 85;
    return p >>> 8;
  endfunction

  task automatic check(string req, int act_v, int exp_v, int act_t, int exp_t_v);
    n_checks++;
    if (act_v !== exp_v || act_t !== exp_t_v) begin
      n_fail++;
      $display("FAIL %s: data_o=%0d tag_o=%0d expected data_o=%0d tag_o=%0d",
               req, act_v, act_t, exp_v, exp_t_v);
    end
  endtask

  // driver: presents one cycle and pushes the expected result
  task automatic drive(logic [1:0] t, int x, string req);
    exp_t e;
    @(negedge clk);
    tag_i  = t;
    data_i = x[DATA_W-1:0];
    if (t == 2'b01) begin
      hc = 0; hb = 0; ha = x;
    end else if (t != 2'b00) begin
      hc = hb; hb = ha; ha = x;
    end
    if (t != 2'b00) last_out = mean_of(ha + hb + hc);
    e.due   = cyc + 2;
    e.tag   = t;
    e.value = last_out;
    e.req   = req;
    exp_q.push_back(e);
  endtask

  // monitor: compares outputs a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        exp_t e;
        int   act;
        e   = exp_q.pop_front();
        act = $signed(data_o);
        check(e.req, act, e.value, int'(tag_o), int'(e.tag));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int act;
    rst_ni = 1'b0;
    tag_i  = 2'b00;
    data_i = '0;
    repeat (2) @(negedge clk);
    // R1: inputs active during reset must not reach the outputs
    tag_i  = 2'b01;
    data_i = 14'd500;
    repeat (3) @(negedge clk);
    act = $signed(data_o);
    check("R1 reset", act, 0, int'(tag_o), 0);
    tag_i  = 2'b00;
    data_i = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    act = $signed(data_o);
    check("R1 after release", act, 0, int'(tag_o), 0);

    // R4 R5 R6 R3: a plain frame
    drive(2'b01, 100, "R4 first");
    drive(2'b10, 50,  "R5 second");
    drive(2'b10, 200, "R6 third");
    drive(2'b10, 200, "R6 middle");
    drive(2'b11, 120, "R3 last");
    // R10: hold while idle
    drive(2'b00, 0,    "R10 hold");
    drive(2'b00, 3333, "R10 hold");
    drive(2'b00, 0,    "R10 hold");

    // R8: small negatives
    drive(2'b01, -1,   "R8 neg first");
    drive(2'b10, -1,   "R8 neg second");
    // R11: idle gap inside frame
    drive(2'b00, 777,  "R11 gap");
    drive(2'b10, -600, "R11 after gap");
    drive(2'b10, 45,   "R6 mixed sign");

    // R7: new frame without a closing tag
    drive(2'b01, 7,    "R7 restart");
    drive(2'b10, 9,    "R7 second");
    drive(2'b11, 11,   "R6 close");

    // R9: full scale
    drive(2'b01, 8191, "R9 pos");
    drive(2'b10, 8191, "R9 pos");
    drive(2'b11, 8191, "R9 pos full");
    drive(2'b01, -8192, "R9 neg");
    drive(2'b10, -8192, "R9 neg");
    drive(2'b11, -8192, "R9 neg full");
    drive(2'b01, 1,    "R7 after full");

    // R6: random frames with idle cycles mixed in
    for (int f = 0; f < 40; f++) begin
      int len;
      len = $urandom_range(1, 7);
      for (int s = 0; s < len; s++) begin
        logic [1:0] t;
        int         v;
        v = int'($urandom_range(0, 16383)) - 8192;
        if (s == 0)            t = 2'b01;
        else if (s == len - 1) t = 2'b11;
        else                   t = 2'b10;
        if ($urandom_range(0, 3) == 0) drive(2'b00, v, "R11 random gap");
        drive(t, v, "R6 random");
      end
    end

    drive(2'b00, 0, "R10 tail");
    drive(2'b00, 0, "R10 tail");
    drive(2'b00, 0, "R2 tail");
    while (exp_q.size() > 0) @(negedge clk);

    // R1: asynchronous reset in the middle of a run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    act = $signed(data_o);
    check("R1 async reset", act, 0, int'(tag_o), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule